// File: doc/BRIEF.md
# Prescaled Timer with Per-Channel Match Actions

This block is a free-running up-counter paced by a programmable prescaler. The prescaler counts clock cycles up to a limit, wraps to zero, and on that wrap gives the main counter one increment. Several match channels each compare a stored value against the main counter on every increment event. Each channel has three independent action bits. One raises a sticky interrupt flag. One returns the main counter to zero. One halts both counters and clears the run bit. A channel can use any combination of the three.

Software reaches every register through a single-cycle write port and a combinational read port. The run bit and a counter-clear hold bit sit in one control word. The interrupt flags are write-one-to-clear, and the interrupt output is high while any flag is set. The register word addresses are: 0 control, 1 prescale limit, 2 prescale count (read only), 3 main count (read only), 4 action control, 5 interrupt flags, and 8+n match value of channel n.

Top module: `match_timer`

## Requirements
- R1: While control bit 0 (run) is 1 and control bit 1 (hold) is 0, the main count increases by one every (L+1) clock cycles, where L is the prescale limit, starting from zero.
- R2: While run is 0, neither the main count nor the prescale count changes.
- R3: A match on channel n, with irq bit 3n of the action control word set, sets bit n of the interrupt flag word. A channel whose irq bit is clear never sets its flag.
- R4: A match on channel n, with reset bit 3n+1 set, makes the main count read 0 in the following increment period, so with match value M the count cycles through 0..M.
- R5: A match on channel n, with stop bit 3n+2 set, clears run. Both counts then hold: the main count keeps its matched value and the prescale count stays at 0.
- R6: Interrupt flags stay set until software writes 1 to them. The irq output is 1 exactly while some flag is set. A flag being set and cleared in the same cycle ends up set.
- R7: The action control word resets to 0 and keeps only bits 11:0. Writes to the bits above are ignored, and those bits read back 0.
- R8: When several channels match on the same increment event, all of their enabled actions apply. With reset and stop together, the main count reads 0 and run is cleared.
- R9: While hold is 1, both counts are held at 0.
- R10: After reset, every readable register reads 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | OR of all interrupt flags |

## Verification
Two pairs of events can land in the same clock edge: a software clear of a flag with a hardware match that sets the same flag, and reset and stop actions from two channels with equal match values. The first pair is forced by timing the clear write onto the exact edge on which the counter reaches the match value; the flag must survive. A second clear, one edge later, must remove it. The second pair is forced by loading two channels with the same value, one set to reset and one set to stop with irq. The result must show a zero count, run cleared and the flag set.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_PRESC = 4'd1;
  localparam logic [3:0] A_PCNT  = 4'd2;
  localparam logic [3:0] A_TCNT  = 4'd3;
  localparam logic [3:0] A_MCTRL = 4'd4;
  localparam logic [3:0] A_IFLAG = 4'd5;
  localparam logic [3:0] A_MATCH = 4'd8;

  // irq in bit 0, reset in bit 1, stop in bit 2 of each 3-bit group
  typedef struct packed {
    logic stop;
    logic clr;
    logic irq;
  } match_act_t;
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int unsigned PW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic [PW-1:0] limit_i,
  output logic          tick_o,
  output logic [PW-1:0] count_o
);
  logic [PW-1:0] cnt_q;
  logic          wrap;

  assign wrap    = (cnt_q >= limit_i);
  assign tick_o  = en_i && !clr_i && wrap;
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i) begin
      if (wrap) cnt_q <= '0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic          zero_i,
  input  logic          halt_i,
  output logic [CW-1:0] count_o
);
  logic [CW-1:0] cnt_q;
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) begin
      // zeroing beats halt, halt beats increment
      if (zero_i)       cnt_q <= '0;
      else if (!halt_i) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mt_match_bank.sv
module mt_match_bank
  import match_timer_pkg::*;
#(
  parameter int unsigned N  = 4,
  parameter int unsigned CW = 32
) (
  input  logic [CW-1:0]        count_i,
  input  logic                 tick_i,
  input  logic [N-1:0][CW-1:0] match_val_i,
  input  logic [3*N-1:0]       act_i,
  output logic [N-1:0]         hit_o,
  output logic [N-1:0]         irq_set_o,
  output logic                 zero_o,
  output logic                 stop_o
);
  logic [N-1:0] zero_v, stop_v;

  for (genvar n = 0; n < N; n++) begin : g_ch
    match_act_t act;
    assign act          = match_act_t'(act_i[3*n +: 3]);
    assign hit_o[n]     = tick_i && (count_i == match_val_i[n]);
    assign irq_set_o[n] = hit_o[n] && act.irq;
    assign zero_v[n]    = hit_o[n] && act.clr;
    assign stop_v[n]    = hit_o[n] && act.stop;
  end

  assign zero_o = |zero_v;
  assign stop_o = |stop_v;
endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int unsigned NUM_MATCH = 4,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned PRE_W     = 32,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned ACT_W = 3 * NUM_MATCH;

  logic                           run_q, hold_q;
  logic [PRE_W-1:0]               presc_q;
  logic [ACT_W-1:0]               act_q;
  logic [NUM_MATCH-1:0]           iflag_q;
  logic [NUM_MATCH-1:0][CNT_W-1:0] match_q;

  logic                 tick, zero_w, stop_w;
  logic [NUM_MATCH-1:0] hit, irq_set;
  logic [PRE_W-1:0]     pcnt;
  logic [CNT_W-1:0]     tcnt;
  logic                 match_sel;
  logic [2:0]           match_idx;

  assign match_sel = addr_i[3];
  assign match_idx = addr_i[2:0];

  mt_prescaler #(.PW(PRE_W)) i_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (run_q),
    .clr_i   (hold_q),
    .limit_i (presc_q),
    .tick_o  (tick),
    .count_o (pcnt)
  );

  mt_counter #(.CW(CNT_W)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (hold_q),
    .tick_i  (tick),
    .zero_i  (zero_w),
    .halt_i  (stop_w),
    .count_o (tcnt)
  );

  mt_match_bank #(.N(NUM_MATCH), .CW(CNT_W)) i_match (
    .count_i     (tcnt),
    .tick_i      (tick),
    .match_val_i (match_q),
    .act_i       (act_q),
    .hit_o       (hit),
    .irq_set_o   (irq_set),
    .zero_o      (zero_w),
    .stop_o      (stop_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      hold_q  <= 1'b0;
      presc_q <= '0;
      act_q   <= '0;
    end else begin
      if (we_i && addr_i == A_CTRL) begin
        run_q  <= wdata_i[0];
        hold_q <= wdata_i[1];
      end
      if (stop_w) run_q <= 1'b0;
      if (we_i && addr_i == A_PRESC) presc_q <= wdata_i[PRE_W-1:0];
      if (we_i && addr_i == A_MCTRL) act_q   <= wdata_i[ACT_W-1:0];
    end
  end

  // hardware set wins over a same-cycle software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) iflag_q <= '0;
    else if (we_i && addr_i == A_IFLAG)
      iflag_q <= (iflag_q & ~wdata_i[NUM_MATCH-1:0]) | irq_set;
    else
      iflag_q <= iflag_q | irq_set;
  end

  for (genvar n = 0; n < NUM_MATCH; n++) begin : g_mreg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) match_q[n] <= '0;
      else if (we_i && match_sel && match_idx == 3'(n))
        match_q[n] <= wdata_i[CNT_W-1:0];
    end
  end

  assign irq_o = |iflag_q;

  always_comb begin
    rdata_o = '0;
    if (match_sel) begin
      for (int n = 0; n < NUM_MATCH; n++)
        if (match_idx == 3'(n)) rdata_o[CNT_W-1:0] = match_q[n];
    end else begin
      case (addr_i)
        A_CTRL:  rdata_o[1:0]           = {hold_q, run_q};
        A_PRESC: rdata_o[PRE_W-1:0]     = presc_q;
        A_PCNT:  rdata_o[PRE_W-1:0]     = pcnt;
        A_TCNT:  rdata_o[CNT_W-1:0]     = tcnt;
        A_MCTRL: rdata_o[ACT_W-1:0]     = act_q;
        A_IFLAG: rdata_o[NUM_MATCH-1:0] = iflag_q;
        default: rdata_o                = '0;
      endcase
    end
  end
endmodule

// File: rtl/mt_checker.sv
module mt_checker
  import match_timer_pkg::*;
#(
  parameter int unsigned N      = 4,
  parameter int unsigned CW     = 32,
  parameter int unsigned PW     = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick,
  input logic [N-1:0]      hit,
  input logic [3*N-1:0]    act,
  input logic              run,
  input logic              hold,
  input logic [CW-1:0]     tcnt,
  input logic [PW-1:0]     pcnt,
  input logic              irq,
  input logic              we,
  input logic [3:0]        addr,
  input logic [DATA_W-1:0] rdata
);
  logic [N-1:0] irq_m, clr_m, stop_m;
  for (genvar n = 0; n < N; n++) begin : g_m
    assign irq_m[n]  = act[3*n];
    assign clr_m[n]  = act[3*n+1];
    assign stop_m[n] = act[3*n+2];
  end

  AST_ZERO_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && |(hit & clr_m)) |=> tcnt == '0); // R4
  AST_STOP_CLEARS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && |(hit & stop_m)) |=> !run); // R5
  AST_IDLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !hold) |=> ($stable(tcnt) && $stable(pcnt))); // R2
  AST_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> (tcnt == '0 && pcnt == '0)); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq && !(we && addr == A_IFLAG)) |=> irq); // R6
  AST_NO_MASKED_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq && !(|(hit & irq_m))) |=> !irq); // R3
  AST_ACT_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr == A_MCTRL) |-> rdata[DATA_W-1:3*N] == '0); // R7
endmodule

bind match_timer mt_checker #(
  .N(NUM_MATCH), .CW(CNT_W), .PW(PRE_W), .DATA_W(DATA_W)
) i_mt_checker (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .tick  (tick),
  .hit   (hit),
  .act   (act_q),
  .run   (run_q),
  .hold  (hold_q),
  .tcnt  (tcnt),
  .pcnt  (pcnt),
  .irq   (irq_o),
  .we    (we_i),
  .addr  (addr_i),
  .rdata (rdata_o)
);

// File: tb/test_match_timer.sv
module test_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;

  localparam logic [3:0] CTRL = 0, PRESC = 1, PCNT = 2, TCNT = 3, MCTRL = 4, IFLAG = 5;

  always #5 clk = ~clk;

  match_timer i_match_timer (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clean();
    wr(CTRL, 32'h2);
    wr(CTRL, 32'h0);
    wr(MCTRL, 32'h0);
    wr(IFLAG, 32'hF);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), v);
      chk("R10 reset read", v, 32'h0);
    end
    chk("R10 irq after reset", {31'b0, irq}, 32'h0);

    // R7 reserved action bits
    wr(MCTRL, 32'hFFFF_FFFF);
    rd(MCTRL, v);
    chk("R7 action word width", v, 32'h0000_0FFF);
    wr(MCTRL, 32'h0);

    // R1 prescale sweep
    for (int p = 0; p < 4; p++) begin
      clean();
      wr(PRESC, 32'(p));
      wr(4'd8, 32'hFFFF);
      wr(CTRL, 32'h1);
      for (int k = 0; k <= 4 * (p + 1); k++) begin
        rd(TCNT, v);
        chk("R1 count vs prescale", v, 32'(k / (p + 1)));
        step(1);
      end
      wr(CTRL, 32'h0);
      // R2 frozen while stopped
      rd(TCNT, v); rd(PCNT, v2);
      step(15);
      rd(TCNT, wdata); chk("R2 count frozen", wdata, v);
      rd(PCNT, wdata); chk("R2 prescale frozen", wdata, v2);
    end

    // R4 reset-on-match sweep
    wr(PRESC, 32'h0);
    for (int m = 1; m <= 4; m++) begin
      clean();
      wr(4'd8, 32'(m));
      wr(MCTRL, 32'h2);
      wr(CTRL, 32'h1);
      for (int k = 0; k < 12; k++) begin
        rd(TCNT, v);
        chk("R4 wrap sequence", v, 32'(k % (m + 1)));
        step(1);
      end
      wr(CTRL, 32'h0);
      rd(IFLAG, v);
      chk("R3 no flag without irq bit", v, 32'h0);
    end

    // R3/R6 flags, set vs clear same edge
    clean();
    wr(4'd8, 32'd2);
    wr(4'd10, 32'd1);
    wr(MCTRL, 32'h3);            // ch0 irq+reset, ch2 no actions
    wr(CTRL, 32'h1);             // count 0
    step(2);                     // count 2
    wr(IFLAG, 32'h1);            // match edge with clear
    rd(IFLAG, v);
    chk("R6 set beats clear", v, 32'h1);
    chk("R6 irq high", {31'b0, irq}, 32'h1);
    rd(TCNT, v);
    chk("R4 zero after match", v, 32'h0);
    step(1);                     // count 1
    wr(IFLAG, 32'h1);            // clear, no match
    rd(IFLAG, v);
    chk("R6 clear on write one", v, 32'h0);
    chk("R6 irq low", {31'b0, irq}, 32'h0);
    step(1);                     // match again
    rd(IFLAG, v);
    chk("R3 flag only enabled channel", v, 32'h1);
    wr(CTRL, 32'h0);

    // R5 stop on match
    clean();
    wr(PRESC, 32'h1);
    wr(4'd11, 32'd4);
    wr(MCTRL, 32'h800);          // ch3 stop
    wr(CTRL, 32'h1);
    step(30);
    rd(TCNT, v); chk("R5 count held at match", v, 32'd4);
    rd(PCNT, v); chk("R5 prescale at zero", v, 32'd0);
    rd(CTRL, v); chk("R5 run cleared", v, 32'd0);

    // R8 reset and stop on same event
    clean();
    wr(PRESC, 32'h0);
    wr(4'd8, 32'd3);
    wr(4'd9, 32'd3);
    wr(MCTRL, 32'h2A);           // ch0 reset, ch1 irq+stop
    wr(CTRL, 32'h1);
    step(10);
    rd(TCNT, v);  chk("R8 count zero", v, 32'd0);
    rd(CTRL, v);  chk("R8 run cleared", v, 32'd0);
    rd(IFLAG, v); chk("R8 flag set", v, 32'h2);

    // R9 hold
    clean();
    wr(4'd8, 32'hFFFF);
    wr(CTRL, 32'h1);
    step(5);
    wr(CTRL, 32'h3);
    step(6);
    rd(TCNT, v); chk("R9 count held zero", v, 32'd0);
    rd(PCNT, v); chk("R9 prescale held zero", v, 32'd0);
    wr(CTRL, 32'h1);
    step(3);
    rd(TCNT, v); chk("R9 resumes after hold", v, 32'd3);
    wr(CTRL, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule